// File: doc/BRIEF.md
# Microcontroller GPIO Bank with Bus-Role Override

This block is a bank of bidirectional port bits for a microcontroller. Every port bit has a register-held output value, a direction bit and an alternate-function select. On ports built with pull-ups, each bit also has a pull-up enable. A bit handed to its alternate function is driven by a peripheral's output value and output enable rather than by the port registers. Pin levels pass through a two-flop synchronizer before software or peripherals see them.

An active-low external-access input takes three of the ports away from software. The low-address port then carries the multiplexed low address byte and data. The high-address port drives address bits 8 to 15. Two bits of the strobe port drive the program-read strobe and the address-latch strobe. This override takes priority over the alternate-function and direction registers.

While the reset pin is held low, every pad is released. The two strobe bits are pulled up only when the external-access input is also low. A synchronous soft reset, raised by the core on a break or an illegal-opcode trap, clears every register in the same way as the reset pin. Pads are modelled as output value, output enable and pull-up enable.

Top module: `gpio_bank`

## Requirements
- R1: After reset every data, direction, pull-up and alternate-select register reads 0. With the external-access input high, no pad has its output enable or its pull-up set.
- R2: For a bit with alternate select 0, a direction bit of 1 enables the pad output and 0 disables it. The pad output value is the data register bit.
- R3: Each bit of a port with pull-ups has a pull-up register bit that drives its pad pull-up. On a port without pull-ups (port 3 by default), writes to that register are ignored, it reads 0, and its pads show no pull-up from it.
- R4: For a bit with alternate select 1, the pad takes its value from the peripheral output and its enable from the peripheral output enable. The direction bit is ignored.
- R5: A read of the data register returns the latched data bit for bits whose direction is 1. For bits whose direction is 0, it returns the synchronized pin level.
- R6: Pin levels reach the synchronized outputs after exactly two rising clock edges.
- R7: While the external-access input is low, every bit of the high-address port (port 1) drives the high address byte with its output enabled. Its alternate-select and direction settings have no effect. Normal control returns when the input goes high.
- R8: While the external-access input is low, strobe port (port 3) bit 4 drives the program-read strobe and bit 5 drives the address-latch strobe, both with output enabled. The other bits of that port keep their register control.
- R9: While the external-access input is low, the low-address port (port 0) drives the low address/data byte. Its output enable follows the bus output-enable input.
- R10: While the reset pin is low, no pad output is enabled. Strobe port bits 4 and 5 have their pull-up set exactly when the external-access input is also low.
- R11: A one-cycle soft reset clears every register on the next rising edge and takes priority over a write in the same cycle.
- R12: The register address is {port index, select}. Select 0 is data, 1 is direction, 2 is pull-up and 3 is alternate select. Writes land on the rising edge, and reads return the stored value combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asserted asynchronously and released synchronously |
| soft_rst | input | 1 | Synchronous clear from break or trap |
| ea_n | input | 1 | Active-low external-access mode |
| reg_addr | input | ADDR_W | Register address {port, select} |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pin_in | input | N_PORTS*PW | Pad input levels |
| pin_out | output | N_PORTS*PW | Pad output values |
| pin_oe | output | N_PORTS*PW | Pad output enables |
| pin_pu | output | N_PORTS*PW | Pad pull-up enables |
| alt_out | input | N_PORTS*PW | Peripheral output values |
| alt_oe | input | N_PORTS*PW | Peripheral output enables |
| sync_in | output | N_PORTS*PW | Synchronized pin levels to peripherals |
| bus_addr_hi | input | PW | High address byte in external access |
| bus_ad_out | input | PW | Low address/data byte in external access |
| bus_ad_oe | input | 1 | Output enable for the low address/data byte |
| bus_psen | input | 1 | Program-read strobe |
| bus_ale | input | 1 | Address-latch strobe |

## Verification
The per-bit source selection is tested with direction, data, peripheral value and peripheral enable patterns that differ in every nibble. This way, a wrong mux leg shows up as a specific wrong nibble.

Readback is tested with a split direction mask against a pin pattern unlike the latch, which separates latched bits from sampled bits. The synchronizer output is sampled after one edge and again after two, which checks its depth.

External-access mode is applied with the override ports already configured for alternate use and partial direction. Both strobe phases are driven, and the release afterwards is checked, so that override priority, bit placement and the return to normal control are each visible.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_ALT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ROLE_PLAIN  = 2'd0,
    ROLE_ADLO   = 2'd1,
    ROLE_ADHI   = 2'd2,
    ROLE_STROBE = 2'd3
  } port_role_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_raw) begin
    if (!rst_n_raw) stage_q <= '0;
    else            stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PW       = 8,
  parameter bit HAS_PULL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  reg_sel_e      wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] data_q,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] pull_q,
  output logic [PW-1:0] alt_q
);
  logic          data_en, dir_en, alt_en;
  logic [PW-1:0] data_d, dir_d, alt_d;

  // next-state and enables; soft reset wins over a write
  always_comb begin
    data_en = soft_rst | (wr_en & (wr_sel == SEL_DATA));
    dir_en  = soft_rst | (wr_en & (wr_sel == SEL_DIR));
    alt_en  = soft_rst | (wr_en & (wr_sel == SEL_ALT));
    data_d  = soft_rst ? '0 : wr_data;
    dir_d   = soft_rst ? '0 : wr_data;
    alt_d   = soft_rst ? '0 : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (dir_en)  dir_q  <= dir_d;
      if (alt_en)  alt_q  <= alt_d;
    end
  end

  generate
    if (HAS_PULL) begin : g_pull
      logic          pull_en;
      logic [PW-1:0] pull_d;
      logic [PW-1:0] pull_r;

      always_comb begin
        pull_en = soft_rst | (wr_en & (wr_sel == SEL_PULL));
        pull_d  = soft_rst ? '0 : wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pull_r <= '0;
        else if (pull_en) pull_r <= pull_d;
      end

      assign pull_q = pull_r;
    end else begin : g_nopull
      assign pull_q = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_bank_pkg::*;
#(
  parameter int         PW       = 8,
  parameter port_role_e ROLE     = ROLE_PLAIN,
  parameter int         PSEN_BIT = 4,
  parameter int         ALE_BIT  = 5
) (
  input  logic          ea_n,
  input  logic          rst_n_pin,
  input  logic [PW-1:0] data_q,
  input  logic [PW-1:0] dir_q,
  input  logic [PW-1:0] pull_q,
  input  logic [PW-1:0] alt_q,
  input  logic [PW-1:0] alt_out,
  input  logic [PW-1:0] alt_oe,
  input  logic [PW-1:0] bus_addr_hi,
  input  logic [PW-1:0] bus_ad_out,
  input  logic          bus_ad_oe,
  input  logic          bus_psen,
  input  logic          bus_ale,
  output logic [PW-1:0] pad_out,
  output logic [PW-1:0] pad_oe,
  output logic [PW-1:0] pad_pu
);
  logic [PW-1:0] strobe_m;
  logic [PW-1:0] force_m, force_o, force_e;
  logic [PW-1:0] reg_o, reg_e;

  always_comb begin
    strobe_m = '0;
    if (ROLE == ROLE_STROBE) begin
      strobe_m[PSEN_BIT] = 1'b1;
      strobe_m[ALE_BIT]  = 1'b1;
    end

    force_m = '0;
    force_o = '0;
    force_e = '0;
    if (!ea_n) begin
      case (ROLE)
        ROLE_ADLO: begin
          force_m = '1;
          force_o = bus_ad_out;
          force_e = {PW{bus_ad_oe}};
        end
        ROLE_ADHI: begin
          force_m = '1;
          force_o = bus_addr_hi;
          force_e = '1;
        end
        ROLE_STROBE: begin
          force_m           = strobe_m;
          force_o[PSEN_BIT] = bus_psen;
          force_o[ALE_BIT]  = bus_ale;
          force_e           = strobe_m;
        end
        default: ;
      endcase
    end

    // register side: alternate select overrides data/direction per bit
    reg_o = (alt_q & alt_out) | (~alt_q & data_q);
    reg_e = (alt_q & alt_oe)  | (~alt_q & dir_q);

    pad_out = (force_m & force_o) | (~force_m & reg_o);
    pad_oe  = ((force_m & force_e) | (~force_m & reg_e)) & {PW{rst_n_pin}};
    pad_pu  = pull_q | (strobe_m & {PW{~rst_n_pin & ~ea_n}});
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int                 N_PORTS    = 4,
  parameter int                 PW         = 8,
  parameter int                 AD_PORT    = 0,
  parameter int                 AH_PORT    = 1,
  parameter int                 STB_PORT   = 3,
  parameter int                 PSEN_BIT   = 4,
  parameter int                 ALE_BIT    = 5,
  parameter logic [N_PORTS-1:0] PULL_PORTS = 4'b0111,
  localparam int                IDX_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int                ADDR_W     = IDX_W + 2,
  localparam int                BITS       = N_PORTS * PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ea_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [BITS-1:0]   pin_in,
  output logic [BITS-1:0]   pin_out,
  output logic [BITS-1:0]   pin_oe,
  output logic [BITS-1:0]   pin_pu,
  input  logic [BITS-1:0]   alt_out,
  input  logic [BITS-1:0]   alt_oe,
  output logic [BITS-1:0]   sync_in,
  input  logic [PW-1:0]     bus_addr_hi,
  input  logic [PW-1:0]     bus_ad_out,
  input  logic              bus_ad_oe,
  input  logic              bus_psen,
  input  logic              bus_ale
);
  logic            rst_n_int;
  logic [BITS-1:0] data_all, dir_all, pull_all, alt_all;
  logic [IDX_W-1:0] idx;
  reg_sel_e        sel;

  assign idx = reg_addr[ADDR_W-1:2];
  assign sel = reg_sel_e'(reg_addr[1:0]);

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n_raw  (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_sync2 #(.W(BITS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pin_in),
    .q     (sync_in)
  );

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      localparam port_role_e ROLE = (p == AD_PORT)  ? ROLE_ADLO :
                                    (p == AH_PORT)  ? ROLE_ADHI :
                                    (p == STB_PORT) ? ROLE_STROBE : ROLE_PLAIN;
      logic wr_hit;
      assign wr_hit = reg_we & (idx == IDX_W'(p));

      gpio_port_regs #(.PW(PW), .HAS_PULL(PULL_PORTS[p])) u_regs (
        .clk      (clk),
        .rst_n    (rst_n_int),
        .soft_rst (soft_rst),
        .wr_en    (wr_hit),
        .wr_sel   (sel),
        .wr_data  (reg_wdata[PW-1:0]),
        .data_q   (data_all[p*PW +: PW]),
        .dir_q    (dir_all[p*PW +: PW]),
        .pull_q   (pull_all[p*PW +: PW]),
        .alt_q    (alt_all[p*PW +: PW])
      );

      gpio_pad_mux #(.PW(PW), .ROLE(ROLE), .PSEN_BIT(PSEN_BIT), .ALE_BIT(ALE_BIT)) u_mux (
        .ea_n        (ea_n),
        .rst_n_pin   (rst_n),
        .data_q      (data_all[p*PW +: PW]),
        .dir_q       (dir_all[p*PW +: PW]),
        .pull_q      (pull_all[p*PW +: PW]),
        .alt_q       (alt_all[p*PW +: PW]),
        .alt_out     (alt_out[p*PW +: PW]),
        .alt_oe      (alt_oe[p*PW +: PW]),
        .bus_addr_hi (bus_addr_hi),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_psen    (bus_psen),
        .bus_ale     (bus_ale),
        .pad_out     (pin_out[p*PW +: PW]),
        .pad_oe      (pin_oe[p*PW +: PW]),
        .pad_pu      (pin_pu[p*PW +: PW])
      );
    end
  endgenerate

  // combinational readback
  always_comb begin
    logic [PW-1:0] d, r, s;
    reg_rdata = '0;
    d = '0;
    r = '0;
    s = '0;
    if (32'(idx) < N_PORTS) begin
      d = data_all[idx*PW +: PW];
      r = dir_all[idx*PW +: PW];
      s = sync_in[idx*PW +: PW];
      case (sel)
        SEL_DATA: reg_rdata[PW-1:0] = (r & d) | (~r & s);
        SEL_DIR:  reg_rdata[PW-1:0] = r;
        SEL_PULL: reg_rdata[PW-1:0] = pull_all[idx*PW +: PW];
        SEL_ALT:  reg_rdata[PW-1:0] = alt_all[idx*PW +: PW];
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int                 N_PORTS    = 4,
  parameter int                 PW         = 8,
  parameter int                 AD_PORT    = 0,
  parameter int                 AH_PORT    = 1,
  parameter int                 STB_PORT   = 3,
  parameter int                 PSEN_BIT   = 4,
  parameter int                 ALE_BIT    = 5,
  parameter logic [N_PORTS-1:0] PULL_PORTS = 4'b0111,
  localparam int                BITS       = N_PORTS * PW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_rst,
  input logic            ea_n,
  input logic [BITS-1:0] pin_out,
  input logic [BITS-1:0] pin_oe,
  input logic [BITS-1:0] pin_pu,
  input logic [PW-1:0]   bus_addr_hi,
  input logic [PW-1:0]   bus_ad_out,
  input logic            bus_ad_oe,
  input logic            bus_psen,
  input logic            bus_ale
);
  localparam int PSEN_IDX = STB_PORT * PW + PSEN_BIT;
  localparam int ALE_IDX  = STB_PORT * PW + ALE_BIT;

  function automatic logic [BITS-1:0] pull_allowed();
    logic [BITS-1:0] m;
    m = '0;
    for (int p = 0; p < N_PORTS; p++)
      if (PULL_PORTS[p]) m[p*PW +: PW] = '1;
    m[PSEN_IDX] = 1'b1;
    m[ALE_IDX]  = 1'b1;
    return m;
  endfunction

  localparam logic [BITS-1:0] ALLOWED = pull_allowed();

  assert_addr_hi_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_n |-> (pin_oe[AH_PORT*PW +: PW] == '1) && (pin_out[AH_PORT*PW +: PW] == bus_addr_hi));

  assert_strobes_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_n |-> pin_oe[PSEN_IDX] && pin_oe[ALE_IDX] &&
              (pin_out[PSEN_IDX] == bus_psen) && (pin_out[ALE_IDX] == bus_ale));

  assert_ad_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_n |-> (pin_out[AD_PORT*PW +: PW] == bus_ad_out) &&
              (pin_oe[AD_PORT*PW +: PW] == {PW{bus_ad_oe}}));

  assert_no_stray_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & ~ALLOWED) == '0);

  assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ea_n || pin_oe == '0));

  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      assert_pads_released_R10: assert ((pin_oe == '0) &&
        (pin_pu[PSEN_IDX] == !ea_n) && (pin_pu[ALE_IDX] == !ea_n));
    end
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .N_PORTS(N_PORTS), .PW(PW), .AD_PORT(AD_PORT), .AH_PORT(AH_PORT),
  .STB_PORT(STB_PORT), .PSEN_BIT(PSEN_BIT), .ALE_BIT(ALE_BIT), .PULL_PORTS(PULL_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ea_n(ea_n),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
  .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
  .bus_psen(bus_psen), .bus_ale(bus_ale)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        ea_n = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_pu, sync_in;
  logic [31:0] alt_out = '0;
  logic [31:0] alt_oe = '0;
  logic [7:0]  bus_addr_hi = '0;
  logic [7:0]  bus_ad_out = '0;
  logic        bus_ad_oe = 1'b0;
  logic        bus_psen = 1'b0;
  logic        bus_ale = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ea_n(ea_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .alt_out(alt_out), .alt_oe(alt_oe), .sync_in(sync_in),
    .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_psen(bus_psen), .bus_ale(bus_ale)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int port, input int sel, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = 4'(port * 4 + sel);
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input int port, input int sel, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(port * 4 + sel);
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    chk("R10", "oe in reset", pin_oe, 32'h0);
    chk("R10", "pu in reset, ea high", pin_pu, 32'h0);
    ea_n = 1'b0;
    #1;
    chk("R10", "pu in reset, ea low", pin_pu, 32'h3000_0000);
    chk("R10", "oe in reset, ea low", pin_oe, 32'h0);
    ea_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        rd(p, s, v);
        chk("R1", "register after reset", {24'h0, v}, 32'h0);
      end
    chk("R1", "oe after reset", pin_oe, 32'h0);
    chk("R1", "pu after reset", pin_pu, 32'h0);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    wr(2, 1, 8'hF0);
    wr(2, 0, 8'hA5);
    chk("R2", "port2 oe", {24'h0, pin_oe[23:16]}, 32'hF0);
    chk("R2", "port2 out", {24'h0, pin_out[23:16]}, 32'hA5);
    rd(2, 1, v);
    chk("R12", "dir readback", {24'h0, v}, 32'hF0);
  endtask

  task automatic t_pullup();
    logic [7:0] v;
    wr(1, 2, 8'h3C);
    chk("R3", "port1 pu", {24'h0, pin_pu[15:8]}, 32'h3C);
    rd(1, 2, v);
    chk("R12", "pull readback", {24'h0, v}, 32'h3C);
    wr(3, 2, 8'hFF);
    rd(3, 2, v);
    chk("R3", "port3 pull reg ignored", {24'h0, v}, 32'h0);
    chk("R3", "port3 pu", {24'h0, pin_pu[31:24]}, 32'h0);
  endtask

  task automatic t_alt();
    logic [7:0] v;
    alt_out[23:16] = 8'h96;
    alt_oe[23:16]  = 8'h05;
    wr(2, 3, 8'h0F);
    chk("R4", "mixed out", {24'h0, pin_out[23:16]}, 32'hA6);
    chk("R4", "mixed oe", {24'h0, pin_oe[23:16]}, 32'hF5);
    rd(2, 3, v);
    chk("R12", "alt readback", {24'h0, v}, 32'h0F);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(0, 1, 8'h0F);
    wr(0, 0, 8'h33);
    @(negedge clk);
    pin_in[7:0] = 8'hC9;
    @(negedge clk);
    chk("R6", "sync after one edge", {24'h0, sync_in[7:0]}, 32'h00);
    @(negedge clk);
    chk("R6", "sync after two edges", {24'h0, sync_in[7:0]}, 32'hC9);
    rd(0, 0, v);
    chk("R5", "data readback mix", {24'h0, v}, 32'hC3);
  endtask

  task automatic t_ext_access();
    wr(1, 3, 8'hFF);
    wr(3, 1, 8'h81);
    wr(3, 0, 8'hFF);
    @(negedge clk);
    alt_out[15:8] = 8'h77;
    bus_addr_hi = 8'h5A;
    bus_ad_out  = 8'hE1;
    bus_ad_oe   = 1'b1;
    bus_psen    = 1'b1;
    bus_ale     = 1'b0;
    ea_n        = 1'b0;
    #1;
    chk("R7", "addr hi out", {24'h0, pin_out[15:8]}, 32'h5A);
    chk("R7", "addr hi oe", {24'h0, pin_oe[15:8]}, 32'hFF);
    chk("R9", "ad out", {24'h0, pin_out[7:0]}, 32'hE1);
    chk("R9", "ad oe driven", {24'h0, pin_oe[7:0]}, 32'hFF);
    chk("R8", "strobe port oe", {24'h0, pin_oe[31:24]}, 32'hB1);
    chk("R8", "strobe port out phase 1", {24'h0, pin_out[31:24]}, 32'hDF);
    @(negedge clk);
    bus_ad_oe = 1'b0;
    bus_psen  = 1'b0;
    bus_ale   = 1'b1;
    #1;
    chk("R9", "ad oe released", {24'h0, pin_oe[7:0]}, 32'h00);
    chk("R8", "strobe port out phase 2", {24'h0, pin_out[31:24]}, 32'hEF);
    @(negedge clk);
    ea_n = 1'b1;
    #1;
    chk("R7", "port1 back to alt out", {24'h0, pin_out[15:8]}, 32'h77);
    chk("R7", "port1 back to alt oe", {24'h0, pin_oe[15:8]}, 32'h00);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    pin_in = '0;
    repeat (3) @(negedge clk);
    soft_rst  = 1'b1;
    reg_addr  = 4'(2 * 4 + 1);
    reg_wdata = 8'hFF;
    reg_we    = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    reg_we   = 1'b0;
    chk("R11", "oe after soft reset", pin_oe, 32'h0);
    chk("R11", "pu after soft reset", pin_pu, 32'h0);
    rd(2, 1, v);
    chk("R11", "dir cleared despite write", {24'h0, v}, 32'h0);
    rd(1, 2, v);
    chk("R11", "pull cleared", {24'h0, v}, 32'h0);
    rd(2, 3, v);
    chk("R11", "alt cleared", {24'h0, v}, 32'h0);
    rd(3, 0, v);
    chk("R11", "data cleared", {24'h0, v}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_direction();
    t_pullup();
    t_alt();
    t_readback();
    t_ext_access();
    t_soft_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule